// File: doc/BRIEF.md
# Three-Phase Bridge Chopping Gate Logic

This block turns the per-phase switch requests of a commutation decoder into gate commands for a three-phase half-bridge. Each phase has one low-side and one high-side switch. A PWM latch bit chops the requested switches. In two-quadrant mode only the low-side switches are chopped. In four-quadrant mode every requested switch is chopped.

A brake request overrides commutation. It opens all high-side switches and closes all low-side switches. The PWM latch can still chop the low-side switches during braking, so current regulation keeps working. Undervoltage, overcurrent and coast requests open every switch in every mode. All outputs come from registers, so a gate command changes only on a rising clock edge.

Top module: `bridge_chop_top`

## Requirements
- R1: While rst_ni is low, ls_cmd_o is 3'b000, hs_cmd_no is 3'b111 and tach_dis_o is 0.
- R2: Every output reflects the inputs sampled at the preceding rising clock edge, which gives exactly one cycle of latency.
- R3: Two-quadrant run (quad4_i=0, no brake, no fault): for each phase i (bit 0 = phase A, bit 1 = B, bit 2 = C), ls_cmd_o[i] = ls_en_i[i] AND pwm_on_i, and hs_cmd_no[i] = NOT hs_en_i[i], independent of pwm_on_i.
- R4: Four-quadrant run (quad4_i=1, no brake, no fault): ls_cmd_o[i] = ls_en_i[i] AND pwm_on_i, and hs_cmd_no[i] = NOT (hs_en_i[i] AND pwm_on_i).
- R5: Brake (brake_i=1, no fault): hs_cmd_no = 3'b111, and all three ls_cmd_o bits equal pwm_on_i, whatever hs_en_i, ls_en_i and quad4_i are.
- R6: When any of uv_i, oc_i or coast_i is 1, ls_cmd_o = 3'b000 and hs_cmd_no = 3'b111. This holds in both chopping modes and while braking.
- R7: tach_dis_o equals the brake_i value sampled at the preceding edge, whether or not a fault is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hs_en_i | input | 3 | High-side requests from the commutation decoder, one bit per phase |
| ls_en_i | input | 3 | Low-side requests from the commutation decoder, one bit per phase |
| pwm_on_i | input | 1 | PWM latch state, 1 = conduction allowed |
| quad4_i | input | 1 | Chopping mode select, 1 = four-quadrant |
| brake_i | input | 1 | Brake request |
| uv_i | input | 1 | Low-supply inhibit |
| oc_i | input | 1 | Peak overcurrent inhibit |
| coast_i | input | 1 | Coast command |
| ls_cmd_o | output | 3 | Low-side gate commands, active high |
| hs_cmd_no | output | 3 | High-side gate commands, active low |
| tach_dis_o | output | 1 | Tachometer disable, raised while braking |

## Verification
The hardest case to reach is a fault or brake that arrives together with a conflicting commutation pattern while the PWM latch is toggling. Only in that case do the priorities between inhibit, brake, quadrant mode and chopping all act at once. To reach it, the stimulus runs a directed sweep over every request pattern in both chopping modes with the latch at both levels. It then runs a brake sweep with quadrant select flipping, and a fault sweep layered on brake. After these come several thousand cycles of random inputs, with brake and fault bits biased so that they often overlap. A behavioural model in the bench predicts the outputs for every cycle, and the bench compares against it on every clock.

// File: rtl/bridge_chop_pkg.sv
package bridge_chop_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_BRAKE = 2'd1,
    MODE_RUN   = 2'd2
  } drive_mode_e;
endpackage

// File: rtl/bc_mode_sel.sv
module bc_mode_sel
  import bridge_chop_pkg::*;
(
  input  logic        uv_i,
  input  logic        oc_i,
  input  logic        coast_i,
  input  logic        brake_i,
  output drive_mode_e mode_o
);
  logic kill;
  assign kill = uv_i | oc_i | coast_i;

  // inhibits dominate brake, brake dominates run
  always_comb begin
    if (kill)         mode_o = MODE_OFF;
    else if (brake_i) mode_o = MODE_BRAKE;
    else              mode_o = MODE_RUN;
  end
endmodule

// File: rtl/bc_phase_gate.sv
module bc_phase_gate
  import bridge_chop_pkg::*;
(
  input  drive_mode_e mode_i,
  input  logic        quad4_i,
  input  logic        pwm_on_i,
  input  logic        hs_en_i,
  input  logic        ls_en_i,
  output logic        hs_on_o,
  output logic        ls_on_o
);
  always_comb begin
    hs_on_o = 1'b0;
    ls_on_o = 1'b0;
    unique case (mode_i)
      MODE_BRAKE: ls_on_o = pwm_on_i;
      MODE_RUN: begin
        ls_on_o = ls_en_i & pwm_on_i;
        hs_on_o = quad4_i ? (hs_en_i & pwm_on_i) : hs_en_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bc_out_stage.sv
module bc_out_stage #(
  parameter int N_PHASE = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_PHASE-1:0] hs_on_i,
  input  logic [N_PHASE-1:0] ls_on_i,
  input  logic               tach_dis_i,
  output logic [N_PHASE-1:0] ls_cmd_o,
  output logic [N_PHASE-1:0] hs_cmd_no,
  output logic               tach_dis_o
);
  localparam logic [N_PHASE-1:0] ALL_OFF_N = {N_PHASE{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ls_cmd_o   <= '0;
      hs_cmd_no  <= ALL_OFF_N;
      tach_dis_o <= 1'b0;
    end else begin
      ls_cmd_o   <= ls_on_i;
      hs_cmd_no  <= ~hs_on_i;
      tach_dis_o <= tach_dis_i;
    end
  end

  // R2: registered outputs follow the previous cycle's decisions
  a_r2_ls_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ls_cmd_o == $past(ls_on_i));
  a_r2_hs_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> hs_cmd_no == ~$past(hs_on_i));
endmodule

// File: rtl/bridge_chop_top.sv
module bridge_chop_top
  import bridge_chop_pkg::*;
#(
  parameter int N_PHASE = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_PHASE-1:0] hs_en_i,
  input  logic [N_PHASE-1:0] ls_en_i,
  input  logic               pwm_on_i,
  input  logic               quad4_i,
  input  logic               brake_i,
  input  logic               uv_i,
  input  logic               oc_i,
  input  logic               coast_i,
  output logic [N_PHASE-1:0] ls_cmd_o,
  output logic [N_PHASE-1:0] hs_cmd_no,
  output logic               tach_dis_o
);
  localparam logic [N_PHASE-1:0] ALL_OFF_N = {N_PHASE{1'b1}};

  drive_mode_e        mode;
  logic [N_PHASE-1:0] hs_on;
  logic [N_PHASE-1:0] ls_on;

  bc_mode_sel u_mode (
    .uv_i    (uv_i),
    .oc_i    (oc_i),
    .coast_i (coast_i),
    .brake_i (brake_i),
    .mode_o  (mode)
  );

  for (genvar p = 0; p < N_PHASE; p++) begin : g_phase
    bc_phase_gate u_gate (
      .mode_i   (mode),
      .quad4_i  (quad4_i),
      .pwm_on_i (pwm_on_i),
      .hs_en_i  (hs_en_i[p]),
      .ls_en_i  (ls_en_i[p]),
      .hs_on_o  (hs_on[p]),
      .ls_on_o  (ls_on[p])
    );
  end

  bc_out_stage #(.N_PHASE(N_PHASE)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hs_on_i    (hs_on),
    .ls_on_i    (ls_on),
    .tach_dis_i (brake_i),
    .ls_cmd_o   (ls_cmd_o),
    .hs_cmd_no  (hs_cmd_no),
    .tach_dis_o (tach_dis_o)
  );

  logic kill_in;
  assign kill_in = uv_i | oc_i | coast_i;

  a_r6_kill_all_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_in |=> (ls_cmd_o == '0) && (hs_cmd_no == ALL_OFF_N));
  a_r5_brake_hs_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brake_i |=> hs_cmd_no == ALL_OFF_N);
  a_r5_brake_ls_uniform: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brake_i && !kill_in) |=> ls_cmd_o == {N_PHASE{$past(pwm_on_i)}});
  a_r3_two_quad_hs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!brake_i && !kill_in && !quad4_i) |=> hs_cmd_no == ~$past(hs_en_i));
  a_r4_four_quad_chop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quad4_i && !pwm_on_i) |=> hs_cmd_no == ALL_OFF_N);
  a_r3_ls_chop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwm_on_i |=> ls_cmd_o == '0);
  a_r7_tach_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> tach_dis_o == $past(brake_i));
endmodule

// File: tb/sim_bridge_chop_top.sv
module sim_bridge_chop_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] hs_en_i = '0, ls_en_i = '0;
  logic       pwm_on_i = 0, quad4_i = 0, brake_i = 0, uv_i = 0, oc_i = 0, coast_i = 0;
  logic [2:0] ls_cmd_o, hs_cmd_no;
  logic       tach_dis_o;

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;
  logic [6:0] exp_q[$];
  string      tag_q[$];

  always #4 clk_i = ~clk_i;

  bridge_chop_top u0 (.*);

  // behavioural reference: {tach, hs_n[2:0], ls[2:0]}
  function automatic logic [6:0] ref_model(logic [2:0] hs, logic [2:0] ls, logic pwm,
                                           logic q4, logic brk, logic uv, logic oc, logic cst);
    logic [2:0] lo, hi_on;
    lo = 3'b000; hi_on = 3'b000;
    if (uv || oc || cst) begin
      lo = 3'b000; hi_on = 3'b000;
    end else if (brk) begin
      lo = pwm ? 3'b111 : 3'b000;
    end else begin
      for (int i = 0; i < 3; i++) begin
        lo[i]    = ls[i] && pwm;
        hi_on[i] = q4 ? (hs[i] && pwm) : hs[i];
      end
    end
    return {brk, ~hi_on, lo};
  endfunction

  function automatic string tag_of(logic q4, logic brk, logic flt);
    if (flt) return "R6";
    if (brk) return "R5";
    if (q4)  return "R4";
    return "R3";
  endfunction

  task automatic check(string tag, int got, int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h at cycle %0d", tag, got, exp, cycles);
    end
  endtask

  // drive one cycle at the falling edge, compare previous prediction first
  task automatic step(logic [2:0] hs, logic [2:0] ls, logic pwm, logic q4,
                      logic brk, logic uv, logic oc, logic cst);
    @(negedge clk_i);
    cycles++;
    if (exp_q.size() > 0) begin
      logic [6:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check({"R2 ", t, " ls"}, ls_cmd_o, e[2:0]);
      check({"R2 ", t, " hs"}, hs_cmd_no, e[5:3]);
      check("R7 tach", tach_dis_o, e[6]);
    end
    hs_en_i = hs; ls_en_i = ls; pwm_on_i = pwm; quad4_i = q4;
    brake_i = brk; uv_i = uv; oc_i = oc; coast_i = cst;
    exp_q.push_back(ref_model(hs, ls, pwm, q4, brk, uv, oc, cst));
    tag_q.push_back(tag_of(q4, brk, uv | oc | cst));
  endtask

  initial begin : watchdog
    while (!done && cycles < 150000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state, inputs deliberately active
    hs_en_i = 3'b111; ls_en_i = 3'b111; pwm_on_i = 1; brake_i = 1;
    repeat (3) @(negedge clk_i);
    check("R1 ls", ls_cmd_o, 3'b000);
    check("R1 hs", hs_cmd_no, 3'b111);
    check("R1 tach", tach_dis_o, 1'b0);
    brake_i = 0;
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R3 R4: every request pattern, both modes, latch both levels
    for (int q = 0; q < 2; q++)
      for (int p = 0; p < 2; p++)
        for (int h = 0; h < 8; h++)
          for (int l = 0; l < 8; l++)
            step(h[2:0], l[2:0], p[0], q[0], 0, 0, 0, 0);

    // R5: brake under varied requests and mode flips
    for (int k = 0; k < 64; k++)
      step(k[2:0], k[5:3], k[0] ^ k[3], k[1], 1, 0, 0, 0);

    // R6: each fault alone, in run and brake
    for (int k = 0; k < 48; k++)
      step(3'b101, 3'b010, 1, k[0], k[1], k[3:2] == 2'd1, k[3:2] == 2'd2,
           k[3:2] != 2'd1 && k[3:2] != 2'd2);

    // random mix with biased brake and faults
    for (int k = 0; k < 4000; k++) begin
      logic [2:0] h, l;
      h = 3'($urandom); l = 3'($urandom);
      step(h, l, 1'($urandom), 1'($urandom), ($urandom % 4) == 0,
           ($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 8) == 0);
    end
    step(0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule